// File: doc/BRIEF.md
# Four-Channel Edge-Selectable Input Capture Unit

This block timestamps events on four input pins. A shared 16-bit up-counter runs while a count-enable input is high. Each of the four channels (A, B, C, D) watches its own pin. When the pin shows the edge that the channel's mode selects, the channel copies the current counter value into its own capture register and raises a sticky flag.

Software reaches the block through a small register bus. It has a combinational read port and a single-cycle write strobe. Through this bus, software writes one 8-bit mode register that holds a 2-bit edge mode for every channel. It also reads the four capture registers, and it reads and clears the capture flags. The flags also appear directly on output pins so that an interrupt source can use them.

A standby request returns all modes to "disabled" without touching the rest of the state.

Top module: `edge_capture_unit`

## Requirements
- R1: After synchronous reset, the mode register reads 0x00, all capture registers read 0x0000, and all flags are 0.
- R2: In the mode register, bits [2c+1:2c] hold the mode of channel c, where A=0, B=1, C=2 and D=3. Bits 1:0 select A and bits 7:6 select D.
- R3: Mode encoding: 2'b00 never captures, 2'b01 captures on a rising pin edge, 2'b10 captures on a falling pin edge, and 2'b11 captures on either edge.
- R4: Each pin passes through a two-flop synchronizer. A pin level first sampled at clock edge k counts as a change at edge k+2. At that edge the channel stores the counter value held just before edge k+2.
- R5: The counter is 16 bits wide and resets to 0. It increments on each clock while count_en is 1, holds while count_en is 0, and wraps from 0xFFFF to 0x0000.
- R6: A capture sets the channel's flag, and the flag stays set. Writing to address 1 clears every flag whose write-data bit (bit c for channel c) is 1. If a capture and a clear hit the same channel in the same cycle, the flag stays set.
- R7: While standby is 1, the mode register is forced to 0x00 at the next clock, even when a write to it happens in the same cycle. No other state changes.
- R8: A mode write takes effect at the next clock. An edge that is evaluated in the same cycle as the write uses the old mode.
- R9: A capture register keeps its value until its next capture, and that capture overwrites it without any overrun protection.
- R10: Bus map: address 0 is the mode register (read/write), address 1 is the flags (read in bits 3:0, write 1 to clear), and addresses 2 to 5 are capture A to D (read-only). Any other address reads 0. Writes to addresses 2 to 7 change nothing.
- R11: Each channel captures only on its own pin and its own mode field. Activity on one channel never changes another channel's capture register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Standby request; clears the mode register |
| count_en | input | 1 | Counter increment enable |
| cap_pin | input | 4 | Asynchronous capture inputs, bit c = channel c |
| bus_addr | input | 3 | Register address |
| bus_wen | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cap_flag | output | 4 | Sticky capture flags, bit c = channel c |

## Verification
The bench builds the unit with its default parameters: a 16-bit counter, two synchronizer stages and a 3-bit address. With these values, a run of about 66,000 enabled cycles carries the counter through its 0xFFFF-to-0x0000 wrap, and captures land on both sides of the wrap. The two-stage synchronizer fixes the capture latency at two clocks. The bench's cycle model can therefore line up mode writes, flag clears and standby requests with the exact cycle in which an edge is judged.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    localparam int NUM_CH  = 4;
    localparam int MODE_W  = 2;
    localparam int CTRL_W  = NUM_CH * MODE_W;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_FLAG = 1;
    localparam int ADDR_CAP0 = 2;

    typedef enum logic [MODE_W-1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic mode_hit(edge_mode_e m, edge_ev_t ev);
        logic hit;
        case (m)
            EDGE_RISE: hit = ev.rise;
            EDGE_FALL: hit = ev.fall;
            EDGE_ANY:  hit = ev.rise | ev.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ecu_pin_sync.sv
module ecu_pin_sync
    import ecu_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output edge_ev_t ev
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        ev.rise = chain_q[STAGES-1] & ~prev_q;
        ev.fall = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/ecu_free_counter.sv
module ecu_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)     cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
    import ecu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_mode_e       mode,
    input  edge_ev_t         ev,
    input  logic [CNT_W-1:0] cnt,
    input  logic             clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag
);

    logic fire;

    always_comb fire = mode_hit(mode, ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
            flag    <= 1'b0;
        end else begin
            if (fire) cap_val <= cnt;
            flag <= fire | (flag & ~clr);
        end
    end

    // R4
    cap_value_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> cap_val == $past(cnt));

    // R3
    no_cap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EDGE_OFF) |=> $stable(cap_val));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              count_en,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] cap_flag
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cap_vals [NUM_CH];
    logic [NUM_CH-1:0] clr_vec;
    logic              wr_ctrl;

    always_comb begin
        wr_ctrl = bus_wen && (bus_addr == ADDR_W'(ADDR_CTRL));
        clr_vec = (bus_wen && (bus_addr == ADDR_W'(ADDR_FLAG)))
                  ? bus_wdata[NUM_CH-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (standby) ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    ecu_free_counter #(.CNT_W(CNT_W)) u_counter (
        .clk (clk),
        .rst (rst),
        .en  (count_en),
        .cnt (cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        edge_ev_t ev;

        ecu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .pin (cap_pin[c]),
            .ev  (ev)
        );

        ecu_channel #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .mode    (edge_mode_e'(ctrl_q[c*MODE_W +: MODE_W])),
            .ev      (ev),
            .cnt     (cnt),
            .clr     (clr_vec[c]),
            .cap_val (cap_vals[c]),
            .flag    (cap_flag[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) bus_rdata = CNT_W'(ctrl_q);
        if (bus_addr == ADDR_W'(ADDR_FLAG)) bus_rdata = CNT_W'(cap_flag);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(ADDR_CAP0 + i)) bus_rdata = cap_vals[i];
        end
    end

    // R7
    standby_clr_chk: assert property (@(posedge clk) disable iff (rst)
        standby |=> ctrl_q == '0);

    // R8
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !standby) |=> ctrl_q == $past(bus_wdata));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == '0 && cap_flag == '0));

endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0;
    logic        count_en = 1'b0;
    logic [3:0]  cap_pin = 4'h0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    edge_capture_unit i_edge_capture_unit (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .count_en  (count_en),
        .cap_pin   (cap_pin),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_flag  (cap_flag)
    );

    // Behavioural reference: pin history queue, integers for state
    logic [3:0] hist[$];
    int         m_cnt;
    logic [7:0] m_ctrl;
    logic [3:0] m_flag;
    int         m_cap[4];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            hist = '{4'h0, 4'h0, 4'h0};
            m_cnt = 0;
            m_ctrl = 8'h00;
            m_flag = 4'h0;
            for (int c = 0; c < 4; c++) m_cap[c] = 0;
        end else begin
            logic [3:0] fire;
            logic [3:0] clr;
            logic [1:0] md;
            hist.push_front(cap_pin);
            for (int c = 0; c < 4; c++) begin
                md = m_ctrl[2*c +: 2];
                fire[c] = (md[0] && hist[2][c] && !hist[3][c]) ||
                          (md[1] && !hist[2][c] && hist[3][c]);
                if (fire[c]) m_cap[c] = m_cnt;
            end
            clr = (bus_wen && bus_addr == 3'd1) ? bus_wdata[3:0] : 4'h0;
            m_flag = (m_flag & ~clr) | fire;
            if (standby) m_ctrl = 8'h00;
            else if (bus_wen && bus_addr == 3'd0) m_ctrl = bus_wdata;
            if (count_en) m_cnt = (m_cnt + 1) % 65536;
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s actual=%0h expected=%0h", req, cur_req, what, act, exp);
        end
    endtask

    task automatic rd_check(string req, int addr, int exp);
        bus_addr = 3'(addr);
        #1;
        check(req, $sformatf("read addr %0d", addr), int'(bus_rdata), exp);
    endtask

    task automatic compare_all();
        check("R6", "flag pins", int'(cap_flag), int'(m_flag));
        rd_check("R2", 0, int'(m_ctrl));
        rd_check("R6", 1, int'(m_flag));
        for (int c = 0; c < 4; c++) rd_check("R4", 2 + c, m_cap[c]);
        rd_check("R10", 6, 0);
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) compare_all();
        bus_wen = 1'b0;
        standby = 1'b0;
    endtask

    task automatic wr(int addr, int data);
        bus_addr = 3'(addr);
        bus_wdata = 8'(data);
        bus_wen = 1'b1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        finish_run();
    end

    initial begin
        ticks(4);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state, literal expectations
        @(negedge clk);
        cur_req = "R1";
        check("R1", "flags after reset", int'(cap_flag), 0);
        rd_check("R1", 0, 0);
        for (int c = 0; c < 4; c++) rd_check("R1", 2 + c, 0);

        // R2/R3/R11: A rise, B fall, C both, D off
        cur_req = "R3";
        count_en = 1'b1;
        wr(0, 8'h39);
        ticks(3);
        cap_pin = 4'b1111; ticks(7);
        cap_pin = 4'b0000; ticks(9);
        cur_req = "R11";
        cap_pin = 4'b0001; ticks(5);
        cap_pin = 4'b0101; ticks(6);
        cap_pin = 4'b0100; ticks(4);
        cap_pin = 4'b1000; ticks(5);
        cur_req = "R3";
        rd_check("R3", 5, 0);   // channel D disabled never captured

        // R9: repeated captures overwrite
        cur_req = "R9";
        wr(0, 8'hFF);
        for (int i = 0; i < 12; i++) begin
            tick();
            cap_pin = ~cap_pin;
            ticks(2 + i % 3);
        end

        // R6: clear flags, and clear colliding with capture
        cur_req = "R6";
        ticks(4);
        wr(1, 8'h0F); tick();
        check("R6", "flags one cycle after clear", int'(cap_flag), 0);
        wr(0, 8'h01);
        tick();
        cap_pin[0] = ~cap_pin[0];
        tick(); tick();
        wr(1, 8'h01);          // clear in the cycle the capture is judged
        tick();
        check("R6", "capture wins over clear", int'(cap_flag[0]), 1);

        // R8: mode write in the cycle an edge is judged uses old mode
        cur_req = "R8";
        ticks(3);
        cap_pin[1] = ~cap_pin[1];
        tick();
        tick();
        wr(0, 8'h0C);          // B->both, judged under old mode (B off)
        ticks(4);
        cap_pin[1] = ~cap_pin[1];
        ticks(4);

        // R7: standby over a simultaneous write
        cur_req = "R7";
        wr(0, 8'hAA);
        standby = 1'b1;
        tick();
        rd_check("R7", 0, 0);
        wr(0, 8'h55); tick();
        standby = 1'b1; tick();
        rd_check("R7", 0, 0);
        check("R7", "flags kept by standby", int'(cap_flag), int'(m_flag));

        // R10: writes to capture addresses ignored
        cur_req = "R10";
        wr(0, 8'hFF); tick();
        cap_pin = ~cap_pin; ticks(4);
        for (int a = 2; a < 8; a++) begin
            wr(a, 8'hA5); tick();
        end
        rd_check("R10", 0, 8'hFF);
        check("R10", "flags after stray writes", int'(cap_flag), 4'hF);

        // R5: counter hold and wrap
        cur_req = "R5";
        count_en = 1'b0;
        cap_pin = ~cap_pin; ticks(6);
        count_en = 1'b1;
        for (int i = 0; i < 66000; i++) begin
            if (i % 3000 == 0) cap_pin = ~cap_pin;
            tick();
        end
        for (int i = 0; i < 12; i++) begin
            cap_pin[i % 4] = ~cap_pin[i % 4];
            tick();
        end

        ticks(5);
        finish_run();
    end

endmodule